// File: doc/BRIEF.md
# MOESI Snooping Line-State Controller

This block keeps the coherence state of every line of one private, direct-mapped cache that sits on a shared snooping bus. Each line holds a tag and one of five states: Modified (M), Owned (O), Exclusive (E), Shared (S) or Invalid (I). A processor read or write is accepted one at a time. The block either completes it locally or requests the bus for a read (RD), read-for-ownership (RDX), upgrade (UPG) or writeback (WB). It also watches the transactions that other agents win on the bus and answers them with a shared response and a dirty-supply response. The dirty-supply response means that this cache, not memory, provides the data.

The Owned state allows dirty sharing. A Modified line that is read by another agent supplies the data and keeps the duty to write it back later, so memory is not updated on that read. An external arbiter grants the bus to one requester per cycle. Every transaction completes in the cycle it is granted, and in that cycle it is seen as a snoop by all other agents. A query port reads the state that is stored for any address.

The request machine has three states. F_IDLE moves to F_RESOLVE when a request is accepted. F_RESOLVE completes a hit locally, or issues bus transactions until the line is usable, and then moves to F_DONE. F_DONE pulses completion and returns to F_IDLE. The line transitions are: fill I→E or I→S; write I→M or S→M or O→M; silent write E→M; snoop-read M→O and E→S; snoop-invalidate of any valid line →I; writeback eviction M→I or O→I; silent eviction E or S, which is replaced by the new fill.

Top module: `moesi_line_ctl`

## Requirements
- R1: After reset every line reads I (state code 0). The bus request and the completion signal are low.
- R2: A read miss issues RD (op code 1) at the line address. The line is filled in E (code 2) when the granted transaction sees no shared response, and in S (code 1) when it sees one.
- R3: A write to a line in M or E completes without any bus request, and the line ends in M (code 4).
- R4: A write to a line in S or O issues UPG (op code 3). The line becomes M only in the cycle that transaction is granted.
- R5: A write miss issues RDX (op code 2), and the line becomes M when it is granted.
- R6: A snooped RD that hits an M line asserts both shared and dirty-supply, and moves the line to O (code 3).
- R7: A snooped RD that hits an E line asserts shared and moves the line to S. A hit on S or O asserts shared, and an O line also asserts dirty-supply. Neither line changes state.
- R8: A snooped RDX or UPG that hits any valid line moves it to I. It asserts dirty-supply when the line was M or O, and never asserts shared.
- R9: A miss whose direct-mapped slot holds a different tag in M or O first issues WB (op code 4) at the victim address, and the victim is then I. A victim in E or S is replaced with no writeback.
- R10: A read that hits a valid line completes with no bus transaction and leaves the state unchanged. The completion pulse lasts one cycle.
- R11: A pending request follows bus order. If a snoop invalidates the S line it was about to upgrade, the request issues RDX instead of UPG.
- R12: Across all agents, each line has at most one copy in M, O or E. M or E exists only when all other copies are I.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request strobe, taken when idle |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | TAG_W+IDX_W | Line address {tag, index} |
| cpu_done | output | 1 | One-cycle completion pulse |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_op | output | 3 | Requested op: 0 none, 1 RD, 2 RDX, 3 UPG, 4 WB |
| bus_addr | output | TAG_W+IDX_W | Address of the requested transaction |
| bus_gnt | input | 1 | This agent's transaction occupies the bus this cycle |
| gnt_shared | input | 1 | OR of other agents' shared responses during the grant |
| snp_valid | input | 1 | Another agent's transaction is on the bus |
| snp_op | input | 3 | Snooped op code |
| snp_addr | input | TAG_W+IDX_W | Snooped address |
| snp_shared | output | 1 | Shared response |
| snp_supply | output | 1 | Dirty-supply response (this cache provides data) |
| qry_addr | input | TAG_W+IDX_W | Address to look up |
| qry_state | output | 3 | Stored state, or I on tag mismatch: 0 I, 1 S, 2 E, 3 O, 4 M |

## Verification
The assertions assume that the bus grant and the snoop valid never reach one agent in the same cycle. They also assume that gnt_shared only has meaning while the agent holds the grant, and that a granted agent always has its request raised. The bench models the bus as a fixed-priority arbiter over three agents. It grants only an agent that is requesting, sends the winner's op and address to every other agent as a snoop, and returns the OR of their shared responses to the winner. This keeps all stimulus inside those assumptions. The scenarios include two simultaneous writes to a line that both agents hold shared, which exercises the bus-order rule.

// File: rtl/moesi_pkg.sv
package moesi_pkg;

    typedef enum logic [2:0] {
        ST_I = 3'd0,
        ST_S = 3'd1,
        ST_E = 3'd2,
        ST_O = 3'd3,
        ST_M = 3'd4
    } line_st_t;

    typedef enum logic [2:0] {
        BOP_NONE = 3'd0,
        BOP_RD   = 3'd1,
        BOP_RDX  = 3'd2,
        BOP_UPG  = 3'd3,
        BOP_WB   = 3'd4
    } bus_op_t;

    localparam int ST_W = 3;

    function automatic logic is_dirty(line_st_t s);
        return (s == ST_M) || (s == ST_O);
    endfunction

endpackage

// File: rtl/moesi_tag_array.sv
module moesi_tag_array
    import moesi_pkg::*;
#(
    parameter int IDX_W = 2,
    parameter int TAG_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     own_we,
    input  logic [IDX_W-1:0]         own_idx,
    input  logic [TAG_W-1:0]         own_tag,
    input  line_st_t                 own_st,
    input  logic                     snp_we,
    input  logic [IDX_W-1:0]         snp_idx,
    input  line_st_t                 snp_st,
    input  logic [IDX_W-1:0]         pnd_idx,
    output logic [TAG_W-1:0]         pnd_tag,
    output line_st_t                 pnd_st,
    output logic [TAG_W-1:0]         snp_tag_rd,
    output line_st_t                 snp_st_rd,
    input  logic [IDX_W-1:0]         qry_idx,
    output logic [TAG_W-1:0]         qry_tag,
    output line_st_t                 qry_st,
    output logic [(1<<IDX_W)*ST_W-1:0] st_flat
);
    localparam int LINES = 1 << IDX_W;

    logic [LINES*TAG_W-1:0] tag_flat;

    generate
        for (genvar g = 0; g < LINES; g++) begin : g_line
            logic [TAG_W-1:0] tag_r;
            line_st_t         st_r;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    tag_r <= '0;
                    st_r  <= ST_I;
                end else if (own_we && own_idx == IDX_W'(g)) begin
                    tag_r <= own_tag;
                    st_r  <= own_st;
                end else if (snp_we && snp_idx == IDX_W'(g)) begin
                    st_r  <= snp_st;
                end
            end

            assign tag_flat[g*TAG_W +: TAG_W] = tag_r;
            assign st_flat[g*ST_W +: ST_W]    = st_r;
        end
    endgenerate

    assign pnd_tag    = tag_flat[pnd_idx*TAG_W +: TAG_W];
    assign pnd_st     = line_st_t'(st_flat[pnd_idx*ST_W +: ST_W]);
    assign snp_tag_rd = tag_flat[snp_idx*TAG_W +: TAG_W];
    assign snp_st_rd  = line_st_t'(st_flat[snp_idx*ST_W +: ST_W]);
    assign qry_tag    = tag_flat[qry_idx*TAG_W +: TAG_W];
    assign qry_st     = line_st_t'(st_flat[qry_idx*ST_W +: ST_W]);

endmodule

// File: rtl/moesi_snoop_resp.sv
module moesi_snoop_resp
    import moesi_pkg::*;
#(
    parameter int TAG_W = 4
) (
    input  logic             snp_valid,
    input  bus_op_t          snp_op,
    input  logic [TAG_W-1:0] snp_tag,
    input  logic [TAG_W-1:0] line_tag,
    input  line_st_t         line_st,
    output logic             resp_shared,
    output logic             resp_supply,
    output logic             upd_en,
    output line_st_t         upd_st
);
    logic hit;

    assign hit = snp_valid && (line_st != ST_I) && (line_tag == snp_tag);

    always_comb begin
        resp_shared = 1'b0;
        resp_supply = 1'b0;
        upd_en      = 1'b0;
        upd_st      = line_st;
        unique case (snp_op)
            BOP_RD: begin
                resp_shared = hit;
                resp_supply = hit && is_dirty(line_st);
                if (hit && line_st == ST_M) begin
                    upd_en = 1'b1;
                    upd_st = ST_O;
                end else if (hit && line_st == ST_E) begin
                    upd_en = 1'b1;
                    upd_st = ST_S;
                end
            end
            BOP_RDX, BOP_UPG: begin
                resp_supply = hit && is_dirty(line_st);
                upd_en      = hit;
                upd_st      = ST_I;
            end
            default: begin
                upd_en = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/moesi_req_fsm.sv
module moesi_req_fsm
    import moesi_pkg::*;
#(
    parameter int IDX_W = 2,
    parameter int TAG_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cpu_req,
    input  logic                   cpu_wr,
    input  logic [TAG_W+IDX_W-1:0] cpu_addr,
    input  logic [TAG_W-1:0]       line_tag,
    input  line_st_t               line_st,
    input  logic                   snp_valid,
    input  logic [IDX_W-1:0]       snp_idx,
    input  logic                   bus_gnt,
    input  logic                   gnt_shared,
    output logic [IDX_W-1:0]       pend_idx,
    output logic                   cpu_done,
    output logic                   bus_req,
    output bus_op_t                bus_op,
    output logic [TAG_W+IDX_W-1:0] bus_addr,
    output logic                   own_we,
    output logic [TAG_W-1:0]       own_tag,
    output line_st_t               own_st
);
    typedef enum logic [1:0] {
        F_IDLE    = 2'd0,
        F_RESOLVE = 2'd1,
        F_DONE    = 2'd2
    } fsm_t;

    fsm_t             st_q, st_d;
    logic             p_wr_q;
    logic [TAG_W-1:0] p_tag_q;
    logic [IDX_W-1:0] p_idx_q;
    logic             hit, local_ok, snp_clash;

    assign pend_idx  = p_idx_q;
    assign hit       = (line_st != ST_I) && (line_tag == p_tag_q);
    assign local_ok  = hit && (!p_wr_q || line_st == ST_M || line_st == ST_E);
    assign snp_clash = snp_valid && (snp_idx == p_idx_q);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= F_IDLE;
        else        st_q <= st_d;
    end

    // Request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_wr_q  <= 1'b0;
            p_tag_q <= '0;
            p_idx_q <= '0;
        end else if (st_q == F_IDLE && cpu_req) begin
            p_wr_q             <= cpu_wr;
            {p_tag_q, p_idx_q} <= cpu_addr;
        end
    end

    // Outputs toward processor and bus: depend on state and stored line only
    always_comb begin
        cpu_done = 1'b0;
        bus_req  = 1'b0;
        bus_op   = BOP_NONE;
        bus_addr = {p_tag_q, p_idx_q};
        unique case (st_q)
            F_IDLE: begin
                cpu_done = 1'b0;
            end
            F_RESOLVE: begin
                if (!local_ok) begin
                    bus_req = 1'b1;
                    if (!hit && is_dirty(line_st)) begin
                        bus_op   = BOP_WB;
                        bus_addr = {line_tag, p_idx_q};
                    end else if (hit) begin
                        bus_op = BOP_UPG;
                    end else begin
                        bus_op = p_wr_q ? BOP_RDX : BOP_RD;
                    end
                end
            end
            F_DONE: begin
                cpu_done = 1'b1;
            end
            default: begin
                cpu_done = 1'b0;
            end
        endcase
    end

    // Next state and line update: depend on grant outcome
    always_comb begin
        st_d    = st_q;
        own_we  = 1'b0;
        own_tag = p_tag_q;
        own_st  = line_st;
        unique case (st_q)
            F_IDLE: begin
                if (cpu_req) st_d = F_RESOLVE;
            end
            F_RESOLVE: begin
                if (local_ok) begin
                    if (!snp_clash) begin
                        own_we = p_wr_q;
                        own_st = p_wr_q ? ST_M : line_st;
                        st_d   = F_DONE;
                    end
                end else if (bus_gnt) begin
                    own_we = 1'b1;
                    unique case (bus_op)
                        BOP_WB: begin
                            own_tag = line_tag;
                            own_st  = ST_I;
                        end
                        BOP_UPG, BOP_RDX: begin
                            own_st = ST_M;
                            st_d   = F_DONE;
                        end
                        BOP_RD: begin
                            own_st = gnt_shared ? ST_S : ST_E;
                            st_d   = F_DONE;
                        end
                        default: begin
                            own_we = 1'b0;
                        end
                    endcase
                end
            end
            F_DONE: begin
                st_d = F_IDLE;
            end
            default: begin
                st_d = F_IDLE;
            end
        endcase
    end

endmodule

// File: rtl/moesi_line_ctl.sv
module moesi_line_ctl
    import moesi_pkg::*;
#(
    parameter int IDX_W = 2,
    parameter int TAG_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cpu_req,
    input  logic                   cpu_wr,
    input  logic [TAG_W+IDX_W-1:0] cpu_addr,
    output logic                   cpu_done,
    output logic                   bus_req,
    output logic [2:0]             bus_op,
    output logic [TAG_W+IDX_W-1:0] bus_addr,
    input  logic                   bus_gnt,
    input  logic                   gnt_shared,
    input  logic                   snp_valid,
    input  logic [2:0]             snp_op,
    input  logic [TAG_W+IDX_W-1:0] snp_addr,
    output logic                   snp_shared,
    output logic                   snp_supply,
    input  logic [TAG_W+IDX_W-1:0] qry_addr,
    output logic [2:0]             qry_state
);
    localparam int LINES = 1 << IDX_W;

    logic [IDX_W-1:0]        pend_idx;
    logic [TAG_W-1:0]        pend_tag;
    line_st_t                pend_state;
    logic [TAG_W-1:0]        snp_line_tag;
    line_st_t                snp_line_st;
    logic [TAG_W-1:0]        qry_tag;
    line_st_t                qry_st;
    logic [LINES*ST_W-1:0]   st_flat;
    logic                    own_we;
    logic [TAG_W-1:0]        own_tag;
    line_st_t                own_st;
    logic                    snp_we;
    line_st_t                snp_st;
    bus_op_t                 fsm_op;

    moesi_tag_array #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .own_we     (own_we),
        .own_idx    (pend_idx),
        .own_tag    (own_tag),
        .own_st     (own_st),
        .snp_we     (snp_we),
        .snp_idx    (snp_addr[IDX_W-1:0]),
        .snp_st     (snp_st),
        .pnd_idx    (pend_idx),
        .pnd_tag    (pend_tag),
        .pnd_st     (pend_state),
        .snp_tag_rd (snp_line_tag),
        .snp_st_rd  (snp_line_st),
        .qry_idx    (qry_addr[IDX_W-1:0]),
        .qry_tag    (qry_tag),
        .qry_st     (qry_st),
        .st_flat    (st_flat)
    );

    moesi_snoop_resp #(.TAG_W(TAG_W)) u_snoop (
        .snp_valid   (snp_valid),
        .snp_op      (bus_op_t'(snp_op)),
        .snp_tag     (snp_addr[TAG_W+IDX_W-1:IDX_W]),
        .line_tag    (snp_line_tag),
        .line_st     (snp_line_st),
        .resp_shared (snp_shared),
        .resp_supply (snp_supply),
        .upd_en      (snp_we),
        .upd_st      (snp_st)
    );

    moesi_req_fsm #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_req    (cpu_req),
        .cpu_wr     (cpu_wr),
        .cpu_addr   (cpu_addr),
        .line_tag   (pend_tag),
        .line_st    (pend_state),
        .snp_valid  (snp_valid),
        .snp_idx    (snp_addr[IDX_W-1:0]),
        .bus_gnt    (bus_gnt),
        .gnt_shared (gnt_shared),
        .pend_idx   (pend_idx),
        .cpu_done   (cpu_done),
        .bus_req    (bus_req),
        .bus_op     (fsm_op),
        .bus_addr   (bus_addr),
        .own_we     (own_we),
        .own_tag    (own_tag),
        .own_st     (own_st)
    );

    assign bus_op    = fsm_op;
    assign qry_state = (qry_tag == qry_addr[TAG_W+IDX_W-1:IDX_W]) ? qry_st : ST_I;

endmodule

// File: rtl/moesi_line_ctl_chk.sv
module moesi_line_ctl_chk
    import moesi_pkg::*;
#(
    parameter int IDX_W = 2,
    parameter int TAG_W = 4
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          cpu_done,
    input logic                          bus_req,
    input logic [2:0]                    bus_op,
    input logic                          bus_gnt,
    input logic                          gnt_shared,
    input logic                          snp_valid,
    input logic [2:0]                    snp_op,
    input logic [IDX_W-1:0]              snp_idx,
    input logic                          snp_shared,
    input logic                          snp_supply,
    input line_st_t                      pend_state,
    input logic [(1<<IDX_W)*ST_W-1:0]    st_flat
);
    logic [IDX_W-1:0] prev_idx;
    logic [2:0]       line_now, line_prev;

    always_ff @(posedge clk) prev_idx <= snp_idx;

    assign line_now  = st_flat[snp_idx*ST_W +: ST_W];
    assign line_prev = st_flat[prev_idx*ST_W +: ST_W];

    p_quiet_after_reset_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (!bus_req && !cpu_done));

    p_fill_state_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_gnt && bus_op == BOP_RD) |=>
            (pend_state == ($past(gnt_shared) ? ST_S : ST_E)));

    p_upgrade_to_m_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_gnt && bus_op == BOP_UPG) |=> (pend_state == ST_M));

    p_rdx_to_m_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_gnt && bus_op == BOP_RDX) |=> (pend_state == ST_M));

    p_rd_m_to_o_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && snp_op == BOP_RD && snp_supply && line_now == ST_M) |=>
            (line_prev == ST_O));

    p_supply_from_dirty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        snp_supply |-> (snp_valid && (line_now == ST_M || line_now == ST_O)));

    p_shared_on_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        snp_shared |-> (snp_valid && snp_op == BOP_RD));

    p_invalidate_dirty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && (snp_op == BOP_RDX || snp_op == BOP_UPG) && snp_supply) |=>
            (line_prev == ST_I));

    p_writeback_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_gnt && bus_op == BOP_WB) |=> (pend_state == ST_I));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> !cpu_done);

endmodule

bind moesi_line_ctl moesi_line_ctl_chk #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_done   (cpu_done),
    .bus_req    (bus_req),
    .bus_op     (bus_op),
    .bus_gnt    (bus_gnt),
    .gnt_shared (gnt_shared),
    .snp_valid  (snp_valid),
    .snp_op     (snp_op),
    .snp_idx    (snp_addr[IDX_W-1:0]),
    .snp_shared (snp_shared),
    .snp_supply (snp_supply),
    .pend_state (pend_state),
    .st_flat    (st_flat)
);

// File: tb/test_moesi_line_ctl.sv
module test_moesi_line_ctl;
    localparam int CLK_PERIOD = 10;
    localparam int N     = 3;
    localparam int IDX_W = 2;
    localparam int TAG_W = 4;
    localparam int AW    = IDX_W + TAG_W;

    localparam logic [2:0] OP_RD = 3'd1, OP_RDX = 3'd2, OP_UPG = 3'd3, OP_WB = 3'd4;
    localparam logic [2:0] S_I = 3'd0, S_S = 3'd1, S_E = 3'd2, S_O = 3'd3, S_M = 3'd4;
    localparam logic [AW-1:0] AX = 6'h05, AY = 6'h09, AZ = 6'h02, AW3 = 6'h03;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] cpu_req, cpu_wr, cpu_done, bus_req, gnt, snp_valid, snp_shared, snp_supply;
    logic [AW-1:0] cpu_addr [N];
    logic [AW-1:0] bus_addr [N];
    logic [AW-1:0] qry_addr [N];
    logic [2:0]    bus_op   [N];
    logic [2:0]    qry_state[N];
    logic [2:0]    bop_b;
    logic [AW-1:0] baddr_b;
    logic          gnt_sh;
    logic          found;
    int            win;
    int            done_cnt [N];
    int            n_chk = 0;
    int            n_fail = 0;

    typedef struct {
        int            agent;
        logic [2:0]    op;
        logic [AW-1:0] addr;
        logic          sh;
        logic [N-1:0]  sup;
        string         req;
    } item_t;
    item_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    generate
        for (genvar i = 0; i < N; i++) begin : g_agent
            moesi_line_ctl #(.IDX_W(IDX_W), .TAG_W(TAG_W)) i_moesi_line_ctl (
                .clk        (clk),
                .rst_n      (rst_n),
                .cpu_req    (cpu_req[i]),
                .cpu_wr     (cpu_wr[i]),
                .cpu_addr   (cpu_addr[i]),
                .cpu_done   (cpu_done[i]),
                .bus_req    (bus_req[i]),
                .bus_op     (bus_op[i]),
                .bus_addr   (bus_addr[i]),
                .bus_gnt    (gnt[i]),
                .gnt_shared (gnt_sh),
                .snp_valid  (snp_valid[i]),
                .snp_op     (bop_b),
                .snp_addr   (baddr_b),
                .snp_shared (snp_shared[i]),
                .snp_supply (snp_supply[i]),
                .qry_addr   (qry_addr[i]),
                .qry_state  (qry_state[i])
            );
        end
    endgenerate

    // Bus model: fixed priority, lowest index wins
    always_comb begin
        found = 1'b0;
        win   = 0;
        gnt   = '0;
        for (int i = 0; i < N; i++) begin
            if (!found && bus_req[i]) begin
                found = 1'b1;
                win   = i;
            end
        end
        if (found) gnt[win] = 1'b1;
        bop_b   = bus_op[win];
        baddr_b = bus_addr[win];
        for (int i = 0; i < N; i++) snp_valid[i] = found && (win != i);
    end

    always_comb gnt_sh = |snp_shared;

    always @(posedge clk) begin
        for (int i = 0; i < N; i++) if (cpu_done[i]) done_cnt[i] <= done_cnt[i] + 1;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Scoreboard monitor: every granted transaction is compared with the queue head
    always @(negedge clk) begin
        item_t e;
        if (rst_n && found) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R3", "unexpected bus op from agent", win, -1);
            end else begin
                e = exp_q.pop_front();
                check(win == e.agent, e.req, "bus winner", win, e.agent);
                check(bop_b == e.op, e.req, "bus op", int'(bop_b), int'(e.op));
                check(baddr_b == e.addr, e.req, "bus addr", int'(baddr_b), int'(e.addr));
                check(gnt_sh == e.sh, e.req, "shared response", int'(gnt_sh), int'(e.sh));
                check(snp_supply == e.sup, e.req, "supply mask", int'(snp_supply), int'(e.sup));
            end
        end
    end

    task automatic expect_bus(input int a, input logic [2:0] op, input logic [AW-1:0] ad,
                              input logic sh, input logic [N-1:0] sup, input string req);
        item_t e;
        e.agent = a; e.op = op; e.addr = ad; e.sh = sh; e.sup = sup; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic wait_cnt(input int a, input int snap);
        while (done_cnt[a] == snap) @(negedge clk);
    endtask

    task automatic access(input int a, input bit wr, input logic [AW-1:0] ad, input string req);
        int snap;
        @(negedge clk);
        snap = done_cnt[a];
        cpu_req[a] = 1'b1; cpu_wr[a] = wr; cpu_addr[a] = ad;
        @(negedge clk);
        cpu_req[a] = 1'b0;
        wait_cnt(a, snap);
        check(exp_q.size() == 0, req, "bus ops still expected", exp_q.size(), 0);
    endtask

    task automatic check_state(input int a, input logic [AW-1:0] ad,
                               input logic [2:0] exp, input string req);
        qry_addr[a] = ad;
        #1;
        check(qry_state[a] == exp, req, $sformatf("state agent %0d addr %0h", a, ad),
              int'(qry_state[a]), int'(exp));
    endtask

    task automatic check_inv();
        logic [AW-1:0] list [4];
        list[0] = AX; list[1] = AY; list[2] = AZ; list[3] = AW3;
        for (int k = 0; k < 4; k++) begin
            int n_own, n_val, n_me;
            n_own = 0; n_val = 0; n_me = 0;
            for (int i = 0; i < N; i++) qry_addr[i] = list[k];
            #1;
            for (int i = 0; i < N; i++) begin
                if (qry_state[i] != S_I) n_val++;
                if (qry_state[i] == S_M || qry_state[i] == S_E) n_me++;
                if (qry_state[i] == S_M || qry_state[i] == S_E || qry_state[i] == S_O) n_own++;
            end
            check(n_own <= 1, "R12", "owner copies", n_own, 1);
            check(n_me == 0 || n_val == 1, "R12", "valid copies beside M/E", n_val, 1);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_chk++;
        n_fail++;
        $display("FAIL R12 watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int s0, s1;
        cpu_req = '0;
        cpu_wr  = '0;
        for (int i = 0; i < N; i++) begin
            cpu_addr[i] = '0;
            qry_addr[i] = '0;
            done_cnt[i] = 0;
        end
        repeat (3) @(negedge clk);
        check(bus_req == '0, "R1", "bus_req in reset", int'(bus_req), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(cpu_done == '0, "R1", "cpu_done after reset", int'(cpu_done), 0);
        check(bus_req == '0, "R1", "bus_req after reset", int'(bus_req), 0);
        for (int i = 0; i < N; i++) check_state(i, AX, S_I, "R1");
        check_state(2, AW3, S_I, "R1");

        // R2: clean fill in E
        expect_bus(0, OP_RD, AX, 1'b0, 3'b000, "R2");
        access(0, 1'b0, AX, "R2");
        check_state(0, AX, S_E, "R2");
        check_inv();

        // R10: read hit stays E, no bus traffic
        access(0, 1'b0, AX, "R10");
        check_state(0, AX, S_E, "R10");

        // R2/R7: second reader fills S, E holder drops to S
        expect_bus(1, OP_RD, AX, 1'b1, 3'b000, "R7");
        access(1, 1'b0, AX, "R2");
        check_state(1, AX, S_S, "R2");
        check_state(0, AX, S_S, "R7");
        check_inv();

        // R4/R8: write to S upgrades, other S invalidated
        expect_bus(0, OP_UPG, AX, 1'b0, 3'b000, "R4");
        access(0, 1'b1, AX, "R4");
        check_state(0, AX, S_M, "R4");
        check_state(1, AX, S_I, "R8");
        check_inv();

        // R3: write to M is silent
        access(0, 1'b1, AX, "R3");
        check_state(0, AX, S_M, "R3");

        // R6: read snoop hits M, agent 0 supplies and goes O
        expect_bus(2, OP_RD, AX, 1'b1, 3'b001, "R6");
        access(2, 1'b0, AX, "R6");
        check_state(0, AX, S_O, "R6");
        check_state(2, AX, S_S, "R6");
        check_inv();

        // R7: O keeps supplying, no state change
        expect_bus(1, OP_RD, AX, 1'b1, 3'b001, "R7");
        access(1, 1'b0, AX, "R7");
        check_state(0, AX, S_O, "R7");
        check_state(1, AX, S_S, "R7");
        check_inv();

        // R4: write to O broadcasts upgrade
        expect_bus(0, OP_UPG, AX, 1'b0, 3'b000, "R4");
        access(0, 1'b1, AX, "R4");
        check_state(0, AX, S_M, "R4");
        check_state(1, AX, S_I, "R8");
        check_state(2, AX, S_I, "R8");
        check_inv();

        // R9: conflicting miss evicts M with writeback first
        expect_bus(0, OP_WB, AX, 1'b0, 3'b000, "R9");
        expect_bus(0, OP_RD, AY, 1'b0, 3'b000, "R9");
        access(0, 1'b0, AY, "R9");
        check_state(0, AX, S_I, "R9");
        check_state(0, AY, S_E, "R9");

        // R9: E victim replaced silently
        expect_bus(0, OP_RD, AX, 1'b0, 3'b000, "R9");
        access(0, 1'b0, AX, "R9");
        check_state(0, AX, S_E, "R9");
        check_state(0, AY, S_I, "R9");
        check_inv();

        // R5: write miss uses RDX
        expect_bus(1, OP_RDX, AZ, 1'b0, 3'b000, "R5");
        access(1, 1'b1, AZ, "R5");
        check_state(1, AZ, S_M, "R5");

        // R8: RDX snoop on M supplies and invalidates
        expect_bus(2, OP_RDX, AZ, 1'b0, 3'b010, "R8");
        access(2, 1'b1, AZ, "R8");
        check_state(2, AZ, S_M, "R5");
        check_state(1, AZ, S_I, "R8");
        check_inv();

        // R11: both S holders write at once; bus order decides
        expect_bus(0, OP_RD, AW3, 1'b0, 3'b000, "R2");
        access(0, 1'b0, AW3, "R2");
        expect_bus(1, OP_RD, AW3, 1'b1, 3'b000, "R2");
        access(1, 1'b0, AW3, "R2");
        check_state(0, AW3, S_S, "R7");
        expect_bus(0, OP_UPG, AW3, 1'b0, 3'b000, "R11");
        expect_bus(1, OP_RDX, AW3, 1'b0, 3'b001, "R11");
        @(negedge clk);
        s0 = done_cnt[0];
        s1 = done_cnt[1];
        cpu_req[0] = 1'b1; cpu_wr[0] = 1'b1; cpu_addr[0] = AW3;
        cpu_req[1] = 1'b1; cpu_wr[1] = 1'b1; cpu_addr[1] = AW3;
        @(negedge clk);
        cpu_req = '0;
        wait_cnt(0, s0);
        wait_cnt(1, s1);
        check(exp_q.size() == 0, "R11", "bus ops still expected", exp_q.size(), 0);
        check_state(0, AW3, S_I, "R11");
        check_state(1, AW3, S_M, "R11");
        check_inv();

        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule